// File: doc/BRIEF.md
# Data and response frame builder

This block produces the outgoing frames of a lightweight acknowledged transport on a 64-bit transmit stream with valid, ready, last and byte-keep signals. A scheduler hands it one frame request at a time: a buffer index, a stream packet number, a repetition number, a last-of-stream flag and, for that final frame, the count of valid data words. The block emits the protocol header, then pulls WORDS payload words of 8 bytes from the packet buffer memory in order. Header and payload bytes are packed big-endian and back to back across the beats. The payload therefore starts in the middle of a beat, and each beat carries the low half of one word followed by the high half of the next.

Command responses arrive in a one-entry response slot. If a response is waiting when a data frame starts, it rides inside that frame's 12-byte response field. If no data frame is ready to start, the response goes out in its own short frame. When the last beat of a data frame is transferred, the block reports the buffer index it has finished with, so the scheduler can recycle or retain the buffer.

Top module: `fb_frame_builder`

## Requirements
- R1: Every frame starts with the destination address (6 bytes), the source address (6 bytes), the protocol identifier 0xFADE and the version 0x0100. Bytes are placed big-endian, with byte 0 of the frame in tx_data[63:56] of beat 0.
- R2: A data frame carries ID 0xA5A5 at bytes 16-17. The 12-byte response field follows (command 2 bytes, sequence 2 bytes, user 8 bytes), then the repetition number (2 bytes), the packet number (4 bytes) and WORDS payload words. The frame is WORDS+5 beats long. tx_keep is 0xFF on every beat except the last, where it is 0xF0. Lanes that carry no frame byte are zero.
- R3: Payload word j of a frame is read from memory address {buffer index, j}, in ascending order, with one cycle of read latency. It occupies frame bytes 36+8j to 43+8j.
- R4: A request with the last flag set yields ID 0xA5A6. Its final payload word is replaced by the request's valid-word count, zero-extended to 64 bits.
- R5: A stand-alone response frame holds ID 0xA55A, a zero 16-bit filler, the command, the sequence and the 8 user bytes, then zeros up to 78 bytes. It is 10 beats long, with tx_keep 0xFC on the last beat.
- R6: A data frame started while a response is waiting carries that response in its response field, and no separate response frame is sent. Otherwise the field is zero. The response is released only when the last beat of the frame carrying it is transferred. A response that arrives during a frame is kept for a later frame.
- R7: A response frame starts only when the block is between frames, a response is waiting and req_valid is low. A waiting request always starts first.
- R8: req_ready is high only between frames. Every frame is followed by at least one cycle with tx_valid low.
- R9: done_valid pulses, with done_buf equal to the frame's buffer index, exactly in the cycle in which the last beat of a data frame is transferred.
- R10: While tx_valid is high and tx_ready is low, tx_data, tx_keep and tx_last hold. tx_valid never drops inside a frame, so with tx_ready held high one beat leaves every cycle.
- R11: rsp_ready is low while a response is waiting. A load offered then is ignored and never appears in any frame.
- R12: After reset, tx_valid, done_valid and mem_rd_en are low, and req_ready and rsp_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_mac | input | 48 | Destination address placed in every frame |
| src_mac | input | 48 | Source address placed in every frame |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Request accepted this cycle (between frames only) |
| req_buf | input | BUF_W | Packet buffer index |
| req_pkt | input | 32 | Stream packet number |
| req_rep | input | 16 | Repetition number |
| req_last | input | 1 | Final frame of the stream |
| req_count | input | log2(WORDS) | Valid word count for the final frame |
| rsp_load | input | 1 | Offer a command response |
| rsp_ready | output | 1 | Response slot empty |
| rsp_cmd | input | 16 | Command code of the response |
| rsp_seq | input | 16 | Command sequence of the response |
| rsp_user | input | 64 | User-defined response bytes |
| mem_rd_en | output | 1 | Buffer memory read strobe |
| mem_rd_addr | output | BUF_W+log2(WORDS) | Buffer memory word address |
| mem_rd_data | input | 64 | Read word, one cycle after the strobe |
| tx_data | output | 64 | Stream beat, byte 0 in the top lane |
| tx_keep | output | 8 | Valid byte lanes, bit 7 for the top lane |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Sink takes the beat |
| tx_last | output | 1 | Final beat of the frame |
| done_valid | output | 1 | Data frame finished |
| done_buf | output | BUF_W | Buffer index of the finished frame |

## Verification
The hardest situation to reach is a response that is loaded while one data frame is on the wire, with the next request already waiting when that frame ends. The block must put the response into the second frame, keep the first frame's field zero, and never send it alone. The bench runs a frame under irregular backpressure, loads the response after the first beat has left, and raises the next request while req_ready is low. It then offers a second response during the carrying frame, which must be refused and never appear. Backpressure also stalls the beat that first uses a freshly read word, so the word must come from the hold path rather than the memory output.

// File: rtl/fb_pkg.sv
package fb_pkg;

  localparam logic [15:0] PROTO_ID  = 16'hFADE;
  localparam logic [15:0] PROTO_VER = 16'h0100;
  localparam logic [15:0] ID_DATA   = 16'hA5A5;
  localparam logic [15:0] ID_FINAL  = 16'hA5A6;
  localparam logic [15:0] ID_RESP   = 16'hA55A;

  // beat index of the closing beat of a stand-alone response frame
  localparam int RESP_LAST_BEAT = 9;

  typedef enum logic [1:0] {
    FB_IDLE = 2'd0,
    FB_DATA = 2'd1,
    FB_RESP = 2'd2
  } fb_state_e;

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] seq;
    logic [63:0] user;
  } fb_rsp_t;

endpackage

// File: rtl/fb_rsp_slot.sv
module fb_rsp_slot
  import fb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  fb_rsp_t load_val,
  input  logic    clear,
  output logic    pending,
  output fb_rsp_t slot_val
);

  logic    pending_q, pending_d;
  logic    load_acc;
  fb_rsp_t slot_q;

  assign load_acc = load && !pending_q;

  always_comb begin
    pending_d = pending_q;
    if (load_acc) begin
      pending_d = 1'b1;
    end else if (clear) begin
      pending_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else begin
      pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (load_acc) begin
      slot_q <= load_val;
    end
  end

  assign pending  = pending_q;
  assign slot_val = slot_q;

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && !clear |=> pending_q && $stable(slot_q)); // R11

endmodule

// File: rtl/fb_payload_fetch.sv
module fb_payload_fetch #(
  parameter int WORDS  = 1024,
  parameter int BUF_W  = 5,
  parameter int BCNT_W = 11,
  localparam int IW = $clog2(WORDS),
  localparam int AW = BUF_W + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              in_data,
  input  logic [BCNT_W-1:0] bcnt,
  input  logic [BUF_W-1:0]  buf_idx,
  input  logic              final_frame,
  input  logic [IW-1:0]     count,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [63:0]       rd_data,
  output logic [31:0]       word_hi,
  output logic [31:0]       prev_lo
);

  localparam logic [BCNT_W-1:0] RD_FIRST = BCNT_W'(3);
  localparam logic [BCNT_W-1:0] RD_LAST  = BCNT_W'(WORDS + 2);
  localparam logic [BCNT_W-1:0] PV_FIRST = BCNT_W'(4);
  localparam logic [BCNT_W-1:0] PV_LAST  = BCNT_W'(WORDS + 3);
  localparam logic [IW-1:0]     IDX_TOP  = IW'(WORDS - 1);

  logic [IW-1:0] rd_idx;
  logic          q_valid_q;
  logic          q_count_q;
  logic [63:0]   hold_q;
  logic [31:0]   prev_lo_q;
  logic [63:0]   word_now;
  logic          prev_en;

  assign rd_idx  = IW'(bcnt - RD_FIRST);
  assign rd_en   = fire && in_data && (bcnt >= RD_FIRST) && (bcnt <= RD_LAST);
  assign rd_addr = {buf_idx, rd_idx};
  assign prev_en = fire && in_data && (bcnt >= PV_FIRST) && (bcnt <= PV_LAST);

  // bypass the freshly returned word, otherwise replay the held copy
  always_comb begin
    if (q_valid_q) begin
      word_now = q_count_q ? {{(64-IW){1'b0}}, count} : rd_data;
    end else begin
      word_now = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid_q <= 1'b0;
      q_count_q <= 1'b0;
    end else begin
      q_valid_q <= rd_en;
      q_count_q <= rd_en && final_frame && (rd_idx == IDX_TOP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (q_valid_q) begin
      hold_q <= word_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lo_q <= '0;
    end else if (prev_en) begin
      prev_lo_q <= word_now[31:0];
    end
  end

  assign word_hi = word_now[63:32];
  assign prev_lo = prev_lo_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + AW'(1)); // R3

endmodule

// File: rtl/fb_beat_fmt.sv
module fb_beat_fmt
  import fb_pkg::*;
#(
  parameter int WORDS  = 1024,
  parameter int BCNT_W = 11
) (
  input  fb_state_e         state,
  input  logic [BCNT_W-1:0] bcnt,
  input  logic [47:0]       dst_mac,
  input  logic [47:0]       src_mac,
  input  logic              final_frame,
  input  logic [15:0]       rep,
  input  logic [31:0]       pkt,
  input  fb_rsp_t           emb,
  input  fb_rsp_t           rsp,
  input  logic [31:0]       word_hi,
  input  logic [31:0]       prev_lo,
  output logic [63:0]       beat,
  output logic [7:0]        keep,
  output logic              last
);

  localparam logic [BCNT_W-1:0] B0        = BCNT_W'(0);
  localparam logic [BCNT_W-1:0] B1        = BCNT_W'(1);
  localparam logic [BCNT_W-1:0] B2        = BCNT_W'(2);
  localparam logic [BCNT_W-1:0] B3        = BCNT_W'(3);
  localparam logic [BCNT_W-1:0] B4        = BCNT_W'(4);
  localparam logic [BCNT_W-1:0] DATA_LAST = BCNT_W'(WORDS + 4);
  localparam logic [BCNT_W-1:0] RESP_LAST = BCNT_W'(RESP_LAST_BEAT);

  logic [63:0] hdr0, hdr1;
  logic [15:0] data_id;

  assign hdr0    = {dst_mac, src_mac[47:32]};
  assign hdr1    = {src_mac[31:0], PROTO_ID, PROTO_VER};
  assign data_id = final_frame ? ID_FINAL : ID_DATA;

  always_comb begin
    beat = 64'h0;
    keep = 8'hFF;
    last = 1'b0;
    if (state == FB_DATA) begin
      if (bcnt == B0) begin
        beat = hdr0;
      end else if (bcnt == B1) begin
        beat = hdr1;
      end else if (bcnt == B2) begin
        beat = {data_id, emb.cmd, emb.seq, emb.user[63:48]};
      end else if (bcnt == B3) begin
        beat = {emb.user[47:0], rep};
      end else if (bcnt == B4) begin
        beat = {pkt, word_hi};
      end else if (bcnt == DATA_LAST) begin
        beat = {prev_lo, 32'h0};
        keep = 8'hF0;
        last = 1'b1;
      end else begin
        beat = {prev_lo, word_hi};
      end
    end else if (state == FB_RESP) begin
      if (bcnt == B0) begin
        beat = hdr0;
      end else if (bcnt == B1) begin
        beat = hdr1;
      end else if (bcnt == B2) begin
        beat = {ID_RESP, 16'h0000, rsp.cmd, rsp.seq};
      end else if (bcnt == B3) begin
        beat = rsp.user;
      end else if (bcnt == RESP_LAST) begin
        keep = 8'hFC;
        last = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fb_frame_builder.sv
module fb_frame_builder
  import fb_pkg::*;
#(
  parameter int WORDS = 1024,
  parameter int BUF_W = 5,
  localparam int IW = $clog2(WORDS),
  localparam int AW = BUF_W + IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      dst_mac,
  input  logic [47:0]      src_mac,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUF_W-1:0] req_buf,
  input  logic [31:0]      req_pkt,
  input  logic [15:0]      req_rep,
  input  logic             req_last,
  input  logic [IW-1:0]    req_count,
  input  logic             rsp_load,
  output logic             rsp_ready,
  input  logic [15:0]      rsp_cmd,
  input  logic [15:0]      rsp_seq,
  input  logic [63:0]      rsp_user,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [63:0]      mem_rd_data,
  output logic [63:0]      tx_data,
  output logic [7:0]       tx_keep,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_last,
  output logic             done_valid,
  output logic [BUF_W-1:0] done_buf
);

  localparam int BCNT_W = $clog2(WORDS + 5);

  fb_state_e         state_q, state_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              has_rsp_q, has_rsp_d;
  logic [BUF_W-1:0]  buf_q;
  logic [31:0]       pkt_q;
  logic [15:0]       rep_q;
  logic              final_q;
  logic [IW-1:0]     count_q;

  logic              req_acc;
  logic              fire;
  logic              frame_end;
  logic              rsp_pending;
  logic              rsp_clear;
  fb_rsp_t           rsp_in, rsp_slot, emb;
  logic [31:0]       word_hi, prev_lo;

  assign req_acc   = (state_q == FB_IDLE) && req_valid;
  assign fire      = tx_valid && tx_ready;
  assign frame_end = fire && tx_last;
  assign rsp_clear = frame_end && ((state_q == FB_RESP) || has_rsp_q);
  assign rsp_in    = '{cmd: rsp_cmd, seq: rsp_seq, user: rsp_user};
  assign emb       = has_rsp_q ? rsp_slot : '0;

  // next-state: request has priority over a waiting response
  always_comb begin
    state_d   = state_q;
    bcnt_d    = bcnt_q;
    has_rsp_d = has_rsp_q;
    case (state_q)
      FB_IDLE: begin
        if (req_valid) begin
          state_d   = FB_DATA;
          bcnt_d    = '0;
          has_rsp_d = rsp_pending;
        end else if (rsp_pending) begin
          state_d   = FB_RESP;
          bcnt_d    = '0;
        end
      end
      default: begin
        if (fire) begin
          if (tx_last) begin
            state_d   = FB_IDLE;
            bcnt_d    = '0;
            has_rsp_d = 1'b0;
          end else begin
            bcnt_d = bcnt_q + BCNT_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FB_IDLE;
      bcnt_q    <= '0;
      has_rsp_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      bcnt_q    <= bcnt_d;
      has_rsp_q <= has_rsp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      pkt_q   <= '0;
      rep_q   <= '0;
      final_q <= 1'b0;
      count_q <= '0;
    end else if (req_acc) begin
      buf_q   <= req_buf;
      pkt_q   <= req_pkt;
      rep_q   <= req_rep;
      final_q <= req_last;
      count_q <= req_count;
    end
  end

  fb_rsp_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rsp_load),
    .load_val (rsp_in),
    .clear    (rsp_clear),
    .pending  (rsp_pending),
    .slot_val (rsp_slot)
  );

  fb_payload_fetch #(
    .WORDS  (WORDS),
    .BUF_W  (BUF_W),
    .BCNT_W (BCNT_W)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .in_data     (state_q == FB_DATA),
    .bcnt        (bcnt_q),
    .buf_idx     (buf_q),
    .final_frame (final_q),
    .count       (count_q),
    .rd_en       (mem_rd_en),
    .rd_addr     (mem_rd_addr),
    .rd_data     (mem_rd_data),
    .word_hi     (word_hi),
    .prev_lo     (prev_lo)
  );

  fb_beat_fmt #(
    .WORDS  (WORDS),
    .BCNT_W (BCNT_W)
  ) u_fmt (
    .state       (state_q),
    .bcnt        (bcnt_q),
    .dst_mac     (dst_mac),
    .src_mac     (src_mac),
    .final_frame (final_q),
    .rep         (rep_q),
    .pkt         (pkt_q),
    .emb         (emb),
    .rsp         (rsp_slot),
    .word_hi     (word_hi),
    .prev_lo     (prev_lo),
    .beat        (tx_data),
    .keep        (tx_keep),
    .last        (tx_last)
  );

  assign tx_valid   = (state_q != FB_IDLE);
  assign req_ready  = (state_q == FB_IDLE);
  assign rsp_ready  = !rsp_pending;
  assign done_valid = frame_end && (state_q == FB_DATA);
  assign done_buf   = buf_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_keep) && $stable(tx_last)); // R10
  AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> tx_valid && (tx_data[63:16] == $past(dst_mac))); // R1
  AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid); // R8
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> tx_valid && tx_ready && tx_last); // R9
  AST_RESP_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FB_IDLE) && (state_d == FB_RESP) |-> !req_valid); // R7
  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_last |-> tx_keep == 8'hFF); // R2

endmodule

// File: tb/tb_fb_frame_builder.sv
module tb_fb_frame_builder;

  localparam int WORDS = 8;
  localparam int BUF_W = 3;
  localparam int IW    = 3;
  localparam int AW    = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic [47:0]      dst_mac = 48'h0211_2233_4455;
  logic [47:0]      src_mac = 48'h0A0B_0C0D_0E0F;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [BUF_W-1:0] req_buf = '0;
  logic [31:0]      req_pkt = '0;
  logic [15:0]      req_rep = '0;
  logic             req_last = 1'b0;
  logic [IW-1:0]    req_count = '0;
  logic             rsp_load = 1'b0;
  logic             rsp_ready;
  logic [15:0]      rsp_cmd = '0;
  logic [15:0]      rsp_seq = '0;
  logic [63:0]      rsp_user = '0;
  logic             mem_rd_en;
  logic [AW-1:0]    mem_rd_addr;
  logic [63:0]      mem_rd_data;
  logic [63:0]      tx_data;
  logic [7:0]       tx_keep;
  logic             tx_valid;
  logic             tx_ready = 1'b1;
  logic             tx_last;
  logic             done_valid;
  logic [BUF_W-1:0] done_buf;

  fb_frame_builder #(.WORDS(WORDS), .BUF_W(BUF_W)) dut (
    .clk(clk), .rst_n(rst_n), .dst_mac(dst_mac), .src_mac(src_mac),
    .req_valid(req_valid), .req_ready(req_ready), .req_buf(req_buf),
    .req_pkt(req_pkt), .req_rep(req_rep), .req_last(req_last), .req_count(req_count),
    .rsp_load(rsp_load), .rsp_ready(rsp_ready), .rsp_cmd(rsp_cmd), .rsp_seq(rsp_seq),
    .rsp_user(rsp_user), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .tx_data(tx_data), .tx_keep(tx_keep),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .done_valid(done_valid), .done_buf(done_buf)
  );

  function automatic logic [63:0] mem_word(input logic [AW-1:0] a);
    return {24'hB1C2D3, 2'b00, a, 24'h0F1E2D, 2'b11, ~a};
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);

  // sink backpressure, changed just after each edge
  bit bp = 1'b0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    tx_ready = bp ? ((cyc % 3) != 0) : 1'b1;
  end

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // stream monitor
  logic [63:0] rec_data [0:3][0:15];
  logic [8:0]  rec_kl   [0:3][0:15];
  int          rec_n    [0:3];
  logic        rec_done [0:3];
  logic [BUF_W-1:0] rec_dbuf [0:3];
  int frames_started = 0, frames_done = 0;
  int gap_err = 0, stab_err = 0, spur_done = 0;
  bit in_frame = 0, stalled = 0;
  int cur = 0;
  logic [63:0] pd; logic [7:0] pk; logic pl;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled && (!tx_valid || tx_data !== pd || tx_keep !== pk || tx_last !== pl)) stab_err++;
      if (in_frame && !tx_valid) gap_err++;
      if (done_valid && !(tx_valid && tx_ready && tx_last)) spur_done++;
      if (tx_valid && tx_ready) begin
        if (!in_frame) begin
          cur = frames_started & 3;
          rec_n[cur] = 0;
          rec_done[cur] = 1'b0;
          in_frame = 1;
          frames_started++;
        end
        if (rec_n[cur] < 16) begin
          rec_data[cur][rec_n[cur]] = tx_data;
          rec_kl[cur][rec_n[cur]]   = {tx_keep, tx_last};
        end
        rec_n[cur]++;
        if (tx_last) begin
          rec_done[cur] = done_valid;
          rec_dbuf[cur] = done_buf;
          in_frame = 0;
          frames_done++;
        end
      end
      stalled = tx_valid && !tx_ready;
      pd = tx_data; pk = tx_keep; pl = tx_last;
    end
  end

  // expected frame bytes, built from the requirement layout
  logic [7:0] eb [0:255];
  int elen;

  task automatic put_be(input int off, input logic [95:0] v, input int n);
    for (int i = 0; i < n; i++) eb[off+i] = v[(n-1-i)*8 +: 8];
  endtask

  task automatic build_hdr();
    for (int i = 0; i < 256; i++) eb[i] = 8'h00;
    put_be(0, {48'h0, dst_mac}, 6);
    put_be(6, {48'h0, src_mac}, 6);
    put_be(12, {64'h0, 32'hFADE_0100}, 4);
  endtask

  task automatic build_data(input logic [BUF_W-1:0] b, input logic [31:0] pkt,
                            input logic [15:0] rep, input bit fin,
                            input logic [IW-1:0] cnt, input logic [95:0] r);
    build_hdr();
    put_be(16, {80'h0, fin ? 16'hA5A6 : 16'hA5A5}, 2);
    put_be(18, r, 12);
    put_be(30, {80'h0, rep}, 2);
    put_be(32, {64'h0, pkt}, 4);
    for (int w = 0; w < WORDS; w++) begin
      logic [63:0] wv;
      wv = (fin && w == WORDS-1) ? {61'h0, cnt} : mem_word({b, IW'(w)});
      put_be(36 + 8*w, {32'h0, wv}, 8);
    end
    elen = 36 + 8*WORDS;
  endtask

  task automatic build_resp(input logic [95:0] r);
    build_hdr();
    put_be(16, {64'h0, 32'hA55A_0000}, 4);
    put_be(20, r, 12);
    elen = 78;
  endtask

  task automatic check_frame(input int slot, input string tag);
    int nb;
    nb = (elen + 7) / 8;
    chk({tag, " beat count"}, 64'(rec_n[slot]), 64'(nb));
    for (int k = 0; k < nb && k < 16; k++) begin
      logic [63:0] ed; logic [7:0] ek;
      for (int i = 0; i < 8; i++) begin
        ed[63-8*i -: 8] = eb[8*k+i];
        ek[7-i] = (8*k + i) < elen;
      end
      chk($sformatf("%s beat %0d data", tag, k), rec_data[slot][k], ed);
      chk($sformatf("%s beat %0d keep/last", tag, k), 64'(rec_kl[slot][k]), 64'({ek, k == nb-1}));
    end
  endtask

  task automatic send_req(input logic [BUF_W-1:0] b, input logic [31:0] pkt,
                          input logic [15:0] rep, input bit fin, input logic [IW-1:0] cnt);
    @(negedge clk);
    req_buf = b; req_pkt = pkt; req_rep = rep; req_last = fin; req_count = cnt;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic load_rsp(input logic [95:0] r, output bit acc);
    @(negedge clk);
    acc = rsp_ready;
    {rsp_cmd, rsp_seq, rsp_user} = r;
    rsp_load = 1'b1;
    @(posedge clk);
    #1 rsp_load = 1'b0;
  endtask

  task automatic wait_done(input int target);
    int t = 0;
    while (frames_done < target && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk("frame completion", 64'(frames_done >= target), 64'(1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 tx_valid", 64'(tx_valid), 0);
    chk("R12 done_valid", 64'(done_valid), 0);
    chk("R12 mem_rd_en", 64'(mem_rd_en), 0);
    chk("R12 req_ready", 64'(req_ready), 1);
    chk("R12 rsp_ready", 64'(rsp_ready), 1);
  endtask

  task automatic t_plain();
    int base = frames_done;
    bp = 1'b0;
    send_req(3'd3, 32'h1234_5678, 16'h0001, 1'b0, '0);
    repeat (4) @(negedge clk);
    chk("R8 req_ready low mid-frame", 64'(req_ready), 0);
    wait_done(base + 1);
    build_data(3'd3, 32'h1234_5678, 16'h0001, 1'b0, '0, 96'h0);
    check_frame(base & 3, "R1 R2 R3 R6 plain");
    chk("R9 done pulse", 64'(rec_done[base & 3]), 1);
    chk("R9 done buffer", 64'(rec_dbuf[base & 3]), 64'(3));
  endtask

  task automatic t_embed_bp();
    int base = frames_done;
    bit acc;
    logic [95:0] ra = {16'h0007, 16'h0042, 64'hDEAD_BEEF_0BAD_F00D};
    logic [95:0] rb = {16'h0009, 16'h0043, 64'h1111_2222_3333_4444};
    bp = 1'b1;
    fork send_req(3'd1, 32'h0000_00A0, 16'h0002, 1'b0, '0); join_none
    while (frames_started <= base) @(negedge clk);
    repeat (2) @(negedge clk);
    load_rsp(ra, acc);
    chk("R11 load accepted when empty", 64'(acc), 1);
    fork send_req(3'd2, 32'h0000_00A1, 16'h0003, 1'b0, '0); join_none
    repeat (2) @(negedge clk);
    chk("R8 request held off mid-frame", 64'(req_ready), 0);
    while (frames_started <= base + 1) @(negedge clk);
    load_rsp(rb, acc);
    chk("R11 load refused when full", 64'(acc), 0);
    wait_done(base + 2);
    build_data(3'd1, 32'h0000_00A0, 16'h0002, 1'b0, '0, 96'h0);
    check_frame(base & 3, "R6 R10 late response not embedded");
    build_data(3'd2, 32'h0000_00A1, 16'h0003, 1'b0, '0, ra);
    check_frame((base + 1) & 3, "R6 R7 embedded response");
    chk("R9 done buffer second", 64'(rec_dbuf[(base + 1) & 3]), 64'(2));
    bp = 1'b0;
    repeat (30) @(negedge clk);
    chk("R7 R11 no separate response frame", 64'(frames_done), 64'(base + 2));
    chk("R6 slot released", 64'(rsp_ready), 1);
  endtask

  task automatic t_final();
    int base = frames_done;
    bp = 1'b0;
    send_req(3'd5, 32'hCAFE_0001, 16'h00FF, 1'b1, 3'd5);
    wait_done(base + 1);
    build_data(3'd5, 32'hCAFE_0001, 16'h00FF, 1'b1, 3'd5, 96'h0);
    check_frame(base & 3, "R4 final frame");
    chk("R9 done final", 64'(rec_done[base & 3]), 1);
  endtask

  task automatic t_resp_alone();
    int base = frames_done;
    bit acc;
    logic [95:0] rd = {16'h0031, 16'h0099, 64'h0102_0304_0506_0708};
    bp = 1'b1;
    load_rsp(rd, acc);
    chk("R11 load idle", 64'(acc), 1);
    wait_done(base + 1);
    build_resp(rd);
    check_frame(base & 3, "R5 response frame");
    chk("R9 no done for response", 64'(rec_done[base & 3]), 0);
    @(negedge clk);
    chk("R6 slot empty after response", 64'(rsp_ready), 1);
    bp = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_embed_bp();
    t_final();
    t_resp_alone();
    repeat (5) @(negedge clk);
    chk("R10 no gaps inside frames", 64'(gap_err), 0);
    chk("R10 stable under stall", 64'(stab_err), 0);
    chk("R9 no stray done", 64'(spur_done), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule